// File: doc/BRIEF.md
# Bus Response Timing Supervisor

This block watches the real-time behaviour of slave replies on a two-line redundant serial bus. Each time a valid, correct master frame ends on line A or line B, it starts measuring two intervals. The first runs from that end strobe to the start of a slave frame on each line. The second runs from the end strobe to the moment a decoded slave frame is ready. The first interval is compared against a response-start limit. The second is compared against a response-ready limit, from which a fixed decoder delay is subtracted.

A slave start that comes too late raises a one-cycle late flag for that line. The surrounding link logic uses this flag to throw away the associated frame. A ready strobe that comes too late raises a separate one-cycle flag.

The supervisor keeps one timer for every pairing of master-end line and slave-start line, and one ready timer for each master-end line. When a timer hits its limit, the current line-status bits decide whether that result counts. These bits are: line enables, which line is trusted, and whether redundancy is lost. Decoding frames and choosing lines are done elsewhere.

Top module: `resp_timing_sup`

## Requirements
- R1: During reset, and in every cycle after reset is released, `late_a`, `late_b` and `ready_late` are 0. This holds until a master-end strobe has been sampled. A measurement that was running when reset asserted produces no flag.
- R2: Let a master-end strobe on the reference line be sampled at clock edge 0. A slave-start strobe on line s sampled at edge d, with 1 <= d <= L*(P+1), stops that line's measurement and produces no late flag for line s. Here L is `cfg_start_lim` (8-bit unsigned, in ticks) and P is `cfg_prescale`.
- R3: If no slave start on line s is sampled at edges 1 .. L*(P+1), the late flag for line s is 1 for exactly the one cycle that follows edge L*(P+1)+1. It stays 0 in every other cycle of that measurement. With L = 0, the flag always follows edge 1.
- R4: One tick lasts `cfg_prescale`+1 clock cycles. Every limit counts ticks measured from the master-end edge.
- R5: Let E = max(`cfg_ready_lim` - DEC_DELAY, 0) and Sc = E*(P+1). If no `sframe_rdy` is sampled at edges 1 .. Sc, `ready_late` is 1 for exactly the one cycle that follows edge Sc+1. Otherwise `ready_late` stays 0.
- R6: A new master-end strobe on a line while its measurements are running restarts them. The restart edge becomes edge 0 for all later timing. A slave start sampled on the same edge as the restart is ignored.
- R7: The reference master line is chosen as follows. If both `line_en_a` and `line_en_b` are 1, the reference is line A when `trust_a` = 1 and line B otherwise. If only one line is enabled, that line is the reference. Only measurements started by a master end on the reference line can raise flags. When neither line is enabled, no flag is ever raised.
- R8: The late flag for a line can assert only if that line is enabled. When `redund_lost` = 1, only the reference line's late flag can assert.
- R9: Late flags are kept per line. A slave start on one line does not stop the measurement for the other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale | input | PRE_W | Tick length minus one, in clocks |
| cfg_start_lim | input | IGN_W | Response-start limit, in ticks |
| cfg_ready_lim | input | SRC_W | Response-ready limit before decoder-delay compensation, in ticks |
| line_en_a | input | 1 | Line A is in use |
| line_en_b | input | 1 | Line B is in use |
| trust_a | input | 1 | Line A is the trusted line (0: line B) |
| redund_lost | input | 1 | The observed line has been lost |
| mend_a | input | 1 | Valid master frame ended on line A |
| mend_b | input | 1 | Valid master frame ended on line B |
| sstart_a | input | 1 | Slave frame started on line A |
| sstart_b | input | 1 | Slave frame started on line B |
| sframe_rdy | input | 1 | Decoded slave frame ready |
| late_a | output | 1 | Line A slave start late; discard frame (one-cycle pulse) |
| late_b | output | 1 | Line B slave start late; discard frame (one-cycle pulse) |
| ready_late | output | 1 | Slave frame ready too late (one-cycle pulse) |

## Verification
A timer whose state is wrong shows up on the ports as a flag pulse on the wrong cycle or the wrong line. The cycle of the expected pulse is known exactly: L*(P+1)+1 edges after the master end for the start check, and Sc+1 edges for the ready check. So an off-by-one in the prescaler, the tick count or the stop logic appears within one measurement window. A timer left running or a wrongly chosen reference line produces a pulse where none is expected, at the latest one window after the master end that started it. The bench sweeps tick length, limits and strobe positions across and around each boundary, and all sixteen line-status combinations on both master lines.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic {
    LINE_A = 1'b0,
    LINE_B = 1'b1
  } line_e;

  localparam int NLINE = 2;
endpackage

// File: rtl/rts_tick_timer.sv
// One interval timer: restarts on start, counts prescaled ticks, stops on
// stop or on reaching the limit. expired is high in the cycle the limit is hit.
module rts_tick_timer #(
  parameter int PRE_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-1:0] lim,
  output logic             expired
);
  logic             run;
  logic [PRE_W-1:0] sub;
  logic [CNT_W-1:0] ticks;

  assign expired = run && (ticks == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      sub   <= '0;
      ticks <= '0;
    end else if (start) begin
      run   <= 1'b1;
      sub   <= '0;
      ticks <= '0;
    end else if (run) begin
      if (stop || expired) begin
        run <= 1'b0;
      end else if (sub == pre) begin
        sub   <= '0;
        ticks <= ticks + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rts_line_select.sv
// Picks the reference master line and which late flags may be raised.
module rts_line_select
  import rts_pkg::*;
(
  input  logic        line_en_a,
  input  logic        line_en_b,
  input  logic        trust_a,
  input  logic        redund_lost,
  output line_e       ref_line,
  output logic        any_en,
  output logic [NLINE-1:0] chk
);
  always_comb begin
    any_en = line_en_a | line_en_b;
    if (line_en_a && line_en_b) ref_line = trust_a ? LINE_A : LINE_B;
    else if (line_en_a)         ref_line = LINE_A;
    else                        ref_line = LINE_B;
    chk[0] = line_en_a && (!redund_lost || ref_line == LINE_A);
    chk[1] = line_en_b && (!redund_lost || ref_line == LINE_B);
  end
endmodule

// File: rtl/resp_timing_sup.sv
module resp_timing_sup
  import rts_pkg::*;
#(
  parameter int          PRE_W     = 4,
  parameter int          IGN_W     = 8,
  parameter int          SRC_W     = 10,
  parameter int unsigned DEC_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [IGN_W-1:0] cfg_start_lim,
  input  logic [SRC_W-1:0] cfg_ready_lim,
  input  logic             line_en_a,
  input  logic             line_en_b,
  input  logic             trust_a,
  input  logic             redund_lost,
  input  logic             mend_a,
  input  logic             mend_b,
  input  logic             sstart_a,
  input  logic             sstart_b,
  input  logic             sframe_rdy,
  output logic             late_a,
  output logic             late_b,
  output logic             ready_late
);
  localparam logic [SRC_W-1:0] DEC_V = SRC_W'(DEC_DELAY);

  logic [NLINE-1:0] mend;
  logic [NLINE-1:0] sstart;
  assign mend   = {mend_b, mend_a};
  assign sstart = {sstart_b, sstart_a};

  // compensated ready limit, saturating at zero
  logic [SRC_W-1:0] rdy_lim_eff;
  always_comb begin
    if (cfg_ready_lim > DEC_V) rdy_lim_eff = cfg_ready_lim - DEC_V;
    else                       rdy_lim_eff = '0;
  end

  // start timers: index [master line][slave line]
  logic [NLINE-1:0][NLINE-1:0] st_exp;
  logic [NLINE-1:0]            rd_exp;

  for (genvar m = 0; m < NLINE; m++) begin : g_master
    for (genvar s = 0; s < NLINE; s++) begin : g_slave
      rts_tick_timer #(.PRE_W(PRE_W), .CNT_W(IGN_W)) u_start_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (mend[m]),
        .stop   (sstart[s]),
        .pre    (cfg_prescale),
        .lim    (cfg_start_lim),
        .expired(st_exp[m][s])
      );
    end
    rts_tick_timer #(.PRE_W(PRE_W), .CNT_W(SRC_W)) u_ready_tmr (
      .clk    (clk),
      .rst    (rst),
      .start  (mend[m]),
      .stop   (sframe_rdy),
      .pre    (cfg_prescale),
      .lim    (rdy_lim_eff),
      .expired(rd_exp[m])
    );
  end

  line_e            ref_line;
  logic             any_en;
  logic [NLINE-1:0] chk;

  rts_line_select u_sel (
    .line_en_a  (line_en_a),
    .line_en_b  (line_en_b),
    .trust_a    (trust_a),
    .redund_lost(redund_lost),
    .ref_line   (ref_line),
    .any_en     (any_en),
    .chk        (chk)
  );

  logic             ref_idx;
  logic [NLINE-1:0] late_q;
  logic             ready_q;
  assign ref_idx = ref_line;

  // line status is evaluated on the cycle a timer stops on its limit
  always_ff @(posedge clk) begin
    if (rst) begin
      late_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      for (int s = 0; s < NLINE; s++) late_q[s] <= chk[s] && st_exp[ref_idx][s];
      ready_q <= any_en && rd_exp[ref_idx];
    end
  end

  assign late_a     = late_q[0];
  assign late_b     = late_q[1];
  assign ready_late = ready_q;
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
  parameter int IGN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [IGN_W-1:0] cfg_start_lim,
  input logic             line_en_a,
  input logic             line_en_b,
  input logic             trust_a,
  input logic             redund_lost,
  input logic             late_a,
  input logic             late_b,
  input logic             ready_late
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!late_a && !late_b && !ready_late));

  a_r3_single_pulse_a: assert property (@(posedge clk) disable iff (rst)
    (late_a && cfg_start_lim != '0) |=> !late_a);

  a_r3_single_pulse_b: assert property (@(posedge clk) disable iff (rst)
    (late_b && cfg_start_lim != '0) |=> !late_b);

  a_r8_flag_a_needs_enable: assert property (@(posedge clk) disable iff (rst)
    late_a |-> $past(line_en_a && (!redund_lost || !line_en_b || trust_a)));

  a_r8_flag_b_needs_enable: assert property (@(posedge clk) disable iff (rst)
    late_b |-> $past(line_en_b && (!redund_lost || !line_en_a || !trust_a)));

  a_r7_ready_needs_line: assert property (@(posedge clk) disable iff (rst)
    ready_late |-> $past(line_en_a || line_en_b));
endmodule

bind resp_timing_sup rts_checker #(.IGN_W(IGN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_start_lim(cfg_start_lim),
  .line_en_a    (line_en_a),
  .line_en_b    (line_en_b),
  .trust_a      (trust_a),
  .redund_lost  (redund_lost),
  .late_a       (late_a),
  .late_b       (late_b),
  .ready_late   (ready_late)
);

// File: tb/resp_timing_sup_bench.sv
`timescale 1ns/100ps
module resp_timing_sup_bench;
  localparam int PRE_W = 4;
  localparam int IGN_W = 8;
  localparam int SRC_W = 10;
  localparam int DEC   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PRE_W-1:0] cfg_prescale = '0;
  logic [IGN_W-1:0] cfg_start_lim = '0;
  logic [SRC_W-1:0] cfg_ready_lim = '0;
  logic en_a = 1'b1, en_b = 1'b1, trust = 1'b1, rlost = 1'b0;
  logic mend_a = 0, mend_b = 0, sstart_a = 0, sstart_b = 0, rdy = 0;
  logic late_a, late_b, ready_late;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  resp_timing_sup #(.PRE_W(PRE_W), .IGN_W(IGN_W), .SRC_W(SRC_W), .DEC_DELAY(DEC)) u_resp_timing_sup (
    .clk(clk), .rst(rst), .cfg_prescale(cfg_prescale), .cfg_start_lim(cfg_start_lim),
    .cfg_ready_lim(cfg_ready_lim), .line_en_a(en_a), .line_en_b(en_b), .trust_a(trust),
    .redund_lost(rlost), .mend_a(mend_a), .mend_b(mend_b), .sstart_a(sstart_a),
    .sstart_b(sstart_b), .sframe_rdy(rdy), .late_a(late_a), .late_b(late_b),
    .ready_late(ready_late));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference model of the line choice (R7, R8)
  function automatic int ref_m();
    if (en_a && en_b) return trust ? 0 : 1;
    if (en_a) return 0;
    if (en_b) return 1;
    return -1;
  endfunction

  function automatic bit chk_m(input int s);
    bit en = (s == 0) ? en_a : en_b;
    return en && (!rlost || s == ref_m());
  endfunction

  // one measurement: master end on line m at edge 0, optional restart at dm2,
  // slave starts at dsa/dsb, ready at dr (0 = none); outputs compared each cycle
  task automatic trial(input int m, input int dm2, input int dsa, input int dsb,
                       input int dr, input string tag);
    int p   = int'(cfg_prescale) + 1;
    int lc  = int'(cfg_start_lim) * p;
    int eff = (int'(cfg_ready_lim) > DEC) ? int'(cfg_ready_lim) - DEC : 0;
    int sc  = eff * p;
    int base = (dm2 > 0) ? dm2 : 0;
    int w   = base + ((lc > sc) ? lc : sc) + 3;
    int rl  = ref_m();
    bit bad = 0;
    int badj = 0, act = 0, exp = 0;
    if (m == 0) mend_a = 1; else mend_b = 1;
    tick();
    mend_a = 0; mend_b = 0;
    for (int j = 1; j <= w; j++) begin
      bit ea, eb, er;
      if (j == dm2) begin if (m == 0) mend_a = 1; else mend_b = 1; end
      sstart_a = (j == dsa);
      sstart_b = (j == dsb);
      rdy      = (j == dr);
      tick();
      mend_a = 0; mend_b = 0; sstart_a = 0; sstart_b = 0; rdy = 0;
      ea = chk_m(0) && rl == m && j == base + lc + 1 && !(dsa > base && dsa <= base + lc);
      eb = chk_m(1) && rl == m && j == base + lc + 1 && !(dsb > base && dsb <= base + lc);
      er = (en_a || en_b) && rl == m && j == base + sc + 1 && !(dr > base && dr <= base + sc);
      if (!bad && ({ready_late, late_b, late_a} !== {er, eb, ea})) begin
        bad = 1; badj = j;
        act = {ready_late, late_b, late_a};
        exp = {er, eb, ea};
      end
    end
    check(!bad, tag, $sformatf("flags {ready,b,a} at edge %0d", badj), act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    check({late_a, late_b, ready_late} === 3'b000, "R1", "flags in reset", {late_a, late_b, ready_late}, 0);
    rst = 0;
    tick();
    check({late_a, late_b, ready_late} === 3'b000, "R1", "flags after reset", {late_a, late_b, ready_late}, 0);

    // R1: reset during a running measurement discards it
    cfg_prescale = 0; cfg_start_lim = 5; cfg_ready_lim = DEC + 5;
    mend_a = 1; tick(); mend_a = 0;
    tick(); tick();
    rst = 1; tick(); tick(); rst = 0;
    begin
      bit seen = 0;
      for (int k = 0; k < 20; k++) begin
        tick();
        if (late_a || late_b || ready_late) seen = 1;
      end
      check(!seen, "R1", "flag after mid-run reset", seen, 0);
    end

    // R2 R3 R4 R9: start-limit sweep, line A start only or both lines
    en_a = 1; en_b = 1; trust = 1; rlost = 0;
    for (int p = 0; p < 3; p++) begin
      for (int l = 0; l < 4; l++) begin
        cfg_prescale = PRE_W'(p);
        cfg_start_lim = IGN_W'(l);
        cfg_ready_lim = SRC_W'(DEC + 1);
        for (int d = 0; d <= l * (p + 1) + 2; d++) begin
          trial(0, 0, d, 0, 1, "R2/R3/R4/R9 single line");
          trial(0, 0, d, d, 1, "R2/R3/R4 both lines");
        end
      end
    end

    // R5: ready-limit sweep with decoder-delay compensation
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s <= DEC + 3; s++) begin
        int sc = ((s > DEC) ? s - DEC : 0) * (p + 1);
        cfg_prescale = PRE_W'(p);
        cfg_start_lim = 1;
        cfg_ready_lim = SRC_W'(s);
        for (int r = 0; r <= sc + 2; r++) trial(0, 0, 1, 1, r, "R5 ready limit");
      end
    end

    // R7 R8: every line-status combination on both master lines
    cfg_prescale = 0; cfg_start_lim = 2; cfg_ready_lim = SRC_W'(DEC + 2);
    for (int c = 0; c < 16; c++) begin
      en_a = c[0]; en_b = c[1]; trust = c[2]; rlost = c[3];
      trial(0, 0, 0, 0, 0, "R7/R8 master A");
      trial(1, 0, 0, 0, 0, "R7/R8 master B");
    end

    // R6: restart by a second master end
    en_a = 1; en_b = 1; trust = 1; rlost = 0;
    cfg_prescale = 1; cfg_start_lim = 3; cfg_ready_lim = SRC_W'(DEC + 20);
    trial(0, 4, 0, 3, 0, "R6 restart, early stop before restart");
    trial(0, 4, 9, 4, 0, "R6 restart, start on restart edge ignored");
    trust = 0;
    trial(1, 2, 0, 8, 0, "R6 restart on line B");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule